// File: doc/BRIEF.md
# Execute-Entry Operand Bypass and Squash Control

This block sits where instructions leave the decode buffer and enter the execute stage of a four-stage in-order pipeline (fetch, decode, execute, store). Operands read during decode can be stale, because the instruction just ahead may not have written its destination register yet. The block keeps a one-entry record of the most recent execute result: its destination register number and its value. When a new instruction enters execute and one of its source register numbers equals the recorded destination, the decoded operand is replaced by the recorded value. The two operands are compared and replaced separately. Only register dependences are repaired. Dependences through memory are neither detected nor fixed.

The execute stage resolves branches. When the instruction being handed over is a taken branch, the block raises a squash strobe in that same cycle. The strobe tells the fetch, decode and inter-stage buffers to discard every younger instruction. Fetch is redirected to the target on the following cycle. The squash also empties the result record, so no value from the discarded path can be bypassed.

The handover follows valid/ready rules. An instruction moves into execute only in a cycle where `dec_valid` and `alu_ready` are both high. While `alu_ready` is low the decode side must hold its fields stable, and the block passes that back-pressure upstream through `dec_ready` in the same cycle. The execute result and branch outcome belong to the instruction being handed over, which means a single-cycle execute.

Top module: `exfwd_unit`

## Requirements
- R1: `alu_valid` equals `dec_valid` and `dec_ready` equals `alu_ready` in the same cycle. `alu_dst` and `alu_wr_en` equal `dec_dst` and `dec_wr_en`. A transfer happens only in a cycle with `dec_valid` = 1 and `alu_ready` = 1.
- R2: When the record is valid and `dec_src_a` equals the recorded destination, `alu_opnd_a` equals the recorded value in the same cycle.
- R3: Operand B is checked separately against `dec_src_b`. When both sources name the recorded register, both operands take the recorded value.
- R4: When the record is invalid, or a source does not match it, that operand passes through from decode unchanged in the same cycle.
- R5: On a transfer, the record takes `dec_dst` and `ex_result`. It becomes valid only if `dec_wr_en` = 1, `ex_result_valid` = 1 and `ex_br_taken` = 0. Any other transfer leaves it invalid, so only the immediately preceding instruction can bypass.
- R6: While there is no transfer, the record is held unchanged. A stalled instruction still sees the bypass from the instruction before it.
- R7: `squash` is 1 exactly in a transfer cycle with `ex_br_taken` = 1. Otherwise it is 0. The instruction that follows a squash receives no bypassed operand.
- R8: After reset the record is invalid and `squash` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode buffer holds an instruction |
| dec_ready | output | 1 | Execute can accept it this cycle |
| dec_src_a | input | IDX_W | Source register number of operand A |
| dec_src_b | input | IDX_W | Source register number of operand B |
| dec_dst | input | IDX_W | Destination register number |
| dec_wr_en | input | 1 | The instruction writes a register |
| dec_opnd_a | input | DATA_W | Operand A as read during decode |
| dec_opnd_b | input | DATA_W | Operand B as read during decode |
| alu_valid | output | 1 | Instruction presented to execute |
| alu_ready | input | 1 | Execute accepts this cycle |
| alu_opnd_a | output | DATA_W | Corrected operand A |
| alu_opnd_b | output | DATA_W | Corrected operand B |
| alu_dst | output | IDX_W | Destination passed through |
| alu_wr_en | output | 1 | Write flag passed through |
| ex_result | input | DATA_W | Execute result of the instruction being handed over |
| ex_result_valid | input | 1 | `ex_result` is a real register value |
| ex_br_taken | input | 1 | The instruction being handed over is a taken branch |
| squash | output | 1 | One-cycle strobe that discards all younger instructions |

## Verification
A corrupted record shows up on the operand outputs at the next transfer whose source matches, within the same cycle the instruction is presented. A record that fails to clear after a squash, a non-writing instruction or an invalid result produces a bypassed value where the decoded operand should pass through. That error is visible on the first following instruction that reads the stale register number. A record that drifts during a stall appears as a wrong operand as soon as the stalled instruction is released.

// File: rtl/exfwd_pkg.sv
package exfwd_pkg;
  // Operand source choice at the entry to execute.
  typedef enum logic {
    SEL_DECODED = 1'b0,
    SEL_BYPASS  = 1'b1
  } opnd_sel_e;

  localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/exfwd_match.sv
module exfwd_match #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             rec_valid,
  input  logic [IDX_W-1:0] rec_dst,
  input  logic [IDX_W-1:0] src,
  output exfwd_pkg::opnd_sel_e sel
);
  // A source is stale only against a record that holds a genuine register write.
  always_comb begin
    sel = exfwd_pkg::SEL_DECODED;
    if (rec_valid && (src == rec_dst)) sel = exfwd_pkg::SEL_BYPASS;
  end
endmodule

// File: rtl/exfwd_opnd_mux.sv
module exfwd_opnd_mux #(
  parameter int unsigned DATA_W = 32
) (
  input  exfwd_pkg::opnd_sel_e sel,
  input  logic [DATA_W-1:0]    decoded,
  input  logic [DATA_W-1:0]    bypass,
  output logic [DATA_W-1:0]    opnd
);
  always_comb begin
    unique case (sel)
      exfwd_pkg::SEL_BYPASS:  opnd = bypass;
      default:                opnd = decoded;
    endcase
  end
endmodule

// File: rtl/exfwd_record.sv
module exfwd_record #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              wr_en,
  input  logic              res_valid,
  input  logic              squash,
  input  logic [IDX_W-1:0]  dst,
  input  logic [DATA_W-1:0] res_data,
  output logic              rec_valid,
  output logic [IDX_W-1:0]  rec_dst,
  output logic [DATA_W-1:0] rec_data
);
  // Loaded on every transfer, so an instruction with no register write
  // evicts the older result instead of letting it reach two instructions ahead.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_dst   <= '0;
      rec_data  <= '0;
    end else if (accept) begin
      rec_valid <= wr_en && res_valid && !squash;
      rec_dst   <= dst;
      rec_data  <= res_data;
    end
  end

  // R6: a stall leaves the record untouched.
  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rec_valid) && $stable(rec_dst) && $stable(rec_data));

  // R7: nothing from a squashed path survives in the record.
  p_squash_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !rec_valid);
endmodule

// File: rtl/exfwd_unit.sv
module exfwd_unit #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [IDX_W-1:0]  dec_src_a,
  input  logic [IDX_W-1:0]  dec_src_b,
  input  logic [IDX_W-1:0]  dec_dst,
  input  logic              dec_wr_en,
  input  logic [DATA_W-1:0] dec_opnd_a,
  input  logic [DATA_W-1:0] dec_opnd_b,
  output logic              alu_valid,
  input  logic              alu_ready,
  output logic [DATA_W-1:0] alu_opnd_a,
  output logic [DATA_W-1:0] alu_opnd_b,
  output logic [IDX_W-1:0]  alu_dst,
  output logic              alu_wr_en,
  input  logic [DATA_W-1:0] ex_result,
  input  logic              ex_result_valid,
  input  logic              ex_br_taken,
  output logic              squash
);
  localparam int unsigned NOPND = exfwd_pkg::NUM_OPND;

  logic                         accept;
  logic                         rec_valid;
  logic [IDX_W-1:0]             rec_dst;
  logic [DATA_W-1:0]            rec_data;
  logic [NOPND-1:0][IDX_W-1:0]  src_vec;
  logic [NOPND-1:0][DATA_W-1:0] dec_vec;
  logic [NOPND-1:0][DATA_W-1:0] alu_vec;

  // Handover is a plain pass-through. Execute's back-pressure reaches decode unchanged.
  assign alu_valid = dec_valid;
  assign dec_ready = alu_ready;
  assign alu_dst   = dec_dst;
  assign alu_wr_en = dec_wr_en;
  assign accept    = dec_valid && alu_ready;

  // The branch resolves in execute, so the squash goes out in the handover cycle.
  assign squash = accept && ex_br_taken;

  assign src_vec = {dec_src_b, dec_src_a};
  assign dec_vec = {dec_opnd_b, dec_opnd_a};
  assign alu_opnd_a = alu_vec[0];
  assign alu_opnd_b = alu_vec[1];

  exfwd_record #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_record (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr_en(dec_wr_en),
    .res_valid(ex_result_valid), .squash(squash), .dst(dec_dst),
    .res_data(ex_result), .rec_valid(rec_valid), .rec_dst(rec_dst),
    .rec_data(rec_data)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    exfwd_pkg::opnd_sel_e sel;
    exfwd_match #(.IDX_W(IDX_W)) u_match (
      .rec_valid(rec_valid), .rec_dst(rec_dst), .src(src_vec[g]), .sel(sel)
    );
    exfwd_opnd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel(sel), .decoded(dec_vec[g]), .bypass(rec_data), .opnd(alu_vec[g])
    );
  end

  // R2: a writer handed over last cycle feeds a matching operand A now.
  p_bypass_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept && dec_wr_en && ex_result_valid && !ex_br_taken)
    && (dec_src_a == $past(dec_dst)) |-> alu_opnd_a == $past(ex_result));

  // R3: the same holds for operand B on its own.
  p_bypass_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept && dec_wr_en && ex_result_valid && !ex_br_taken)
    && (dec_src_b == $past(dec_dst)) |-> alu_opnd_b == $past(ex_result));

  // R5: a non-writing or invalid-result predecessor yields no bypass.
  p_no_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(accept && !(dec_wr_en && ex_result_valid))
    |-> alu_opnd_a == dec_opnd_a && alu_opnd_b == dec_opnd_b);

  // R7: the instruction after a squash uses its decoded operands.
  p_after_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(squash)
    |-> alu_opnd_a == dec_opnd_a && alu_opnd_b == dec_opnd_b);

  // R7: a squash only accompanies a real handover.
  p_squash_needs_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> dec_valid && dec_ready);
endmodule

// File: tb/exfwd_unit_test.sv
module exfwd_unit_test;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0, alu_ready = 1'b0, dec_wr_en = 1'b0;
  logic ex_result_valid = 1'b0, ex_br_taken = 1'b0;
  logic [IDX_W-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic [DATA_W-1:0] dec_opnd_a = '0, dec_opnd_b = '0, ex_result = '0;
  logic dec_ready, alu_valid, alu_wr_en, squash;
  logic [DATA_W-1:0] alu_opnd_a, alu_opnd_b;
  logic [IDX_W-1:0] alu_dst;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // Bench model of the bypass record.
  logic m_valid = 1'b0;
  logic [IDX_W-1:0] m_dst = '0;
  logic [DATA_W-1:0] m_data = '0;

  always #2.5 clk = ~clk;

  exfwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uut (.*);

  function automatic logic [DATA_W-1:0] exp_opnd(logic [IDX_W-1:0] src,
                                                 logic [DATA_W-1:0] dec);
    return (m_valid && src == m_dst) ? m_data : dec;
  endfunction

  task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Check combinational outputs mid-cycle, then advance the model to the edge.
  task automatic step();
    logic xfer;
    #1;
    xfer = dec_valid && alu_ready;
    check("R1", {alu_valid, dec_ready, alu_wr_en}, {dec_valid, alu_ready, dec_wr_en});
    check("R1", alu_dst, dec_dst);
    check((m_valid && dec_src_a == m_dst) ? "R2" : "R4", alu_opnd_a, exp_opnd(dec_src_a, dec_opnd_a));
    check((m_valid && dec_src_b == m_dst) ? "R3" : "R4", alu_opnd_b, exp_opnd(dec_src_b, dec_opnd_b));
    check("R7", squash, xfer && ex_br_taken);
    if (xfer) begin
      m_valid = dec_wr_en && ex_result_valid && !ex_br_taken;
      m_dst   = dec_dst;
      m_data  = ex_result;
    end
    @(negedge clk);
  endtask

  task automatic drive(logic v, logic rdy, int sa, int sb, int d, logic we,
                       int oa, int ob, int res, logic rv, logic br);
    dec_valid = v; alu_ready = rdy; dec_src_a = sa[IDX_W-1:0]; dec_src_b = sb[IDX_W-1:0];
    dec_dst = d[IDX_W-1:0]; dec_wr_en = we; dec_opnd_a = oa; dec_opnd_b = ob;
    ex_result = res; ex_result_valid = rv; ex_br_taken = br;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R8: reset state, no squash and no bypass of a register id 0.
    check("R8", squash, 1'b0);
    rst_n = 1'b1;
    drive(1, 1, 0, 0, 1, 0, 32'h11, 32'h22, 0, 0, 0);
    #1; check("R8", alu_opnd_a, 32'h11);
    @(negedge clk);

    // Chain: move 10 to r1, r1+r1 to r2, r2+r2 to r3 (R2, R3).
    drive(1, 1, 0, 0, 1, 1, 0, 0, 10, 1, 0); step();
    drive(1, 1, 1, 1, 2, 1, 0, 0, 20, 1, 0); step();
    check("R3", {alu_opnd_a, alu_opnd_b}, 0); // sanity: model applies next step
    drive(1, 1, 2, 2, 3, 1, 0, 0, 40, 1, 0);
    #1; check("R3", alu_opnd_a, 20); check("R3", alu_opnd_b, 20);
    step();

    // R6: stall keeps the record, released instruction still bypasses.
    drive(1, 0, 3, 5, 4, 1, 7, 8, 99, 1, 0); step(); step();
    drive(1, 1, 3, 5, 4, 1, 7, 8, 99, 1, 0);
    #1; check("R6", alu_opnd_a, 40); check("R6", alu_opnd_b, 8);
    step();

    // R5: invalid result breaks the chain; non-writer evicts the record.
    drive(1, 1, 4, 4, 6, 1, 1, 2, 55, 0, 0); step();
    drive(1, 1, 6, 6, 7, 1, 3, 4, 66, 1, 0);
    #1; check("R5", alu_opnd_a, 3);
    step();
    drive(1, 1, 0, 0, 7, 0, 0, 0, 0, 1, 0); step();
    drive(1, 1, 7, 7, 8, 1, 5, 6, 0, 1, 0);
    #1; check("R5", alu_opnd_b, 6);
    step();

    // R7: taken branch squashes and the next instruction sees no bypass.
    drive(1, 1, 0, 0, 9, 1, 0, 0, 77, 1, 1);
    #1; check("R7", squash, 1'b1);
    step();
    drive(1, 1, 9, 9, 1, 1, 12, 13, 0, 1, 0);
    #1; check("R7", alu_opnd_a, 12);
    step();

    // Random mix over a small register set so matches are frequent.
    for (int i = 0; i < 600; i++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 1), $urandom, $urandom, $urandom,
            $urandom_range(0, 4) != 0, $urandom_range(0, 7) == 0);
      step();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule